// File: doc/BRIEF.md
# Cooperative PUF Bit Regenerator

This block returns one stable response bit for a primary ring-oscillator pair over the full operating temperature range. A pair whose faster oscillator changes with temperature is still usable. At enrollment, a helper record is stored for the pair. It holds two temperature codes that bound the band where the pair cannot be trusted, the index of a cooperating secondary pair, and a flag saying whether that secondary pair's bit must be inverted.

On each request the block compares the current temperature code against the two bounds. Below the band, the primary raw bit is used as it is. Inside the band, the bit of the cooperating pair is taken from the raw-bit vector and inverted if the flag asks for it. Above the band, the primary raw bit is inverted. If the helper record is marked invalid, no cooperation takes place and the primary bit passes through. The corrected bit arrives with a one-cycle valid strobe. A 2-bit code reports which path produced it.

Top module: `coop_puf_regen`

## Requirements
- R1: On a request, the temperature code is classified against the helper bounds. A code strictly below the lower bound is low (region_o = 0). Otherwise, a code strictly above the upper bound is high (region_o = 2). Any remaining code, including codes equal to either bound, is in the unreliable band (region_o = 1).
- R2: In the low region, bit_o equals the primary raw bit sampled with the request.
- R3: In the unreliable band, bit_o is taken from raw_bits_i at the bit position given by the secondary index, where position 0 is the least significant bit. When the flag is clear, it equals that bit.
- R4: In the unreliable band with the inversion flag set, bit_o is the inverse of the selected secondary bit.
- R5: In the high region, bit_o is the inverse of the primary raw bit.
- R6: When the helper-valid input is 0, bit_o equals the primary raw bit whatever the temperature, and region_o reads 3.
- R7: valid_o is 1 in exactly the cycle after each clock edge that samples req_i high, and 0 otherwise.
- R8: Without a request, bit_o and region_o keep the values of the last result.
- R9: While reset is held, valid_o, bit_o and region_o are 0.
- R10: If the lower bound exceeds the upper bound, codes that are below the lower bound and also above the upper bound count as low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request a regenerated bit |
| temp_i | input | 8 | Current temperature code |
| prim_bit_i | input | 1 | Raw bit of the primary pair |
| raw_bits_i | input | 64 | Raw bits of all pairs |
| hlp_valid_i | input | 1 | Helper record is valid |
| hlp_sec_idx_i | input | 6 | Index of the cooperating pair |
| hlp_sec_inv_i | input | 1 | Invert the cooperating pair's bit |
| hlp_t_lo_i | input | 8 | Lower bound of the unreliable band |
| hlp_t_hi_i | input | 8 | Upper bound of the unreliable band |
| bit_o | output | 1 | Regenerated bit |
| valid_o | output | 1 | Strobe, one cycle after a request |
| region_o | output | 2 | Path used: 0 low, 1 band, 2 high, 3 bypass |

## Verification
Every result, whether bit, region code or strobe, is due on the first rising edge after the edge that samples the request. Inputs are driven on falling edges. The behavioural model updates its expected values on the rising edge that samples the request, and the design's outputs are compared on the following falling edge, so each comparison falls one edge after the request. On idle cycles the same falling-edge comparison confirms that the previous result is held and the strobe stays low. Directed cases cover each bound value, its neighbours, the extreme secondary indices, and reversed bounds.

// File: rtl/coop_puf_pkg.sv
package coop_puf_pkg;
  typedef enum logic [1:0] {
    RGN_LOW  = 2'd0,
    RGN_MID  = 2'd1,
    RGN_HIGH = 2'd2,
    RGN_BYP  = 2'd3
  } rgn_e;
endpackage

// File: rtl/coop_puf_classify.sv
module coop_puf_classify
  import coop_puf_pkg::*;
#(
  parameter int TEMP_W = 8
) (
  input  logic [TEMP_W-1:0] temp_i,
  input  logic [TEMP_W-1:0] lo_i,
  input  logic [TEMP_W-1:0] hi_i,
  input  logic              hlp_ok_i,
  output rgn_e              rgn_o
);
  logic below_lo, above_hi;
  assign below_lo = temp_i < lo_i;
  assign above_hi = temp_i > hi_i;

  // low wins when the bounds are reversed
  always_comb begin
    if (!hlp_ok_i)     rgn_o = RGN_BYP;
    else if (below_lo) rgn_o = RGN_LOW;
    else if (above_hi) rgn_o = RGN_HIGH;
    else               rgn_o = RGN_MID;
  end
endmodule

// File: rtl/coop_puf_sec_sel.sv
module coop_puf_sec_sel #(
  parameter int N_PAIRS = 64,
  parameter int IDX_W   = (N_PAIRS > 1) ? $clog2(N_PAIRS) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic [N_PAIRS-1:0] raw_i,
  input  logic [IDX_W-1:0]   idx_i,
  input  logic               inv_i,
  output logic               bit_o
);
  logic sel_bit;

  generate
    if ((1 << IDX_W) == N_PAIRS) begin : g_full
      assign sel_bit = raw_i[idx_i];
    end else begin : g_part
      // indices past the last pair read as 0
      always_comb begin
        sel_bit = 1'b0;
        for (int i = 0; i < N_PAIRS; i++) begin
          if (idx_i == IDX_W'(i)) sel_bit = raw_i[i];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   bit_o <= 1'b0;
    else if (en_i) bit_o <= sel_bit ^ inv_i;
  end
endmodule

// File: rtl/coop_puf_resolve.sv
module coop_puf_resolve
  import coop_puf_pkg::*;
(
  input  rgn_e rgn_i,
  input  logic prim_i,
  input  logic sec_i,
  output logic bit_o
);
  always_comb begin
    unique case (rgn_i)
      RGN_MID:  bit_o = sec_i;
      RGN_HIGH: bit_o = ~prim_i;
      default:  bit_o = prim_i;
    endcase
  end
endmodule

// File: rtl/coop_puf_regen.sv
module coop_puf_regen
  import coop_puf_pkg::*;
#(
  parameter int TEMP_W  = 8,
  parameter int N_PAIRS = 64,
  localparam int IDX_W  = (N_PAIRS > 1) ? $clog2(N_PAIRS) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_i,
  input  logic [TEMP_W-1:0]  temp_i,
  input  logic               prim_bit_i,
  input  logic [N_PAIRS-1:0] raw_bits_i,
  input  logic               hlp_valid_i,
  input  logic [IDX_W-1:0]   hlp_sec_idx_i,
  input  logic               hlp_sec_inv_i,
  input  logic [TEMP_W-1:0]  hlp_t_lo_i,
  input  logic [TEMP_W-1:0]  hlp_t_hi_i,
  output logic               bit_o,
  output logic               valid_o,
  output logic [1:0]         region_o
);
  rgn_e rgn_d, rgn_q;
  logic prim_q, sec_q, valid_q;

  coop_puf_classify #(.TEMP_W(TEMP_W)) i_classify (
    .temp_i   (temp_i),
    .lo_i     (hlp_t_lo_i),
    .hi_i     (hlp_t_hi_i),
    .hlp_ok_i (hlp_valid_i),
    .rgn_o    (rgn_d)
  );

  coop_puf_sec_sel #(.N_PAIRS(N_PAIRS), .IDX_W(IDX_W)) i_sec_sel (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (req_i),
    .raw_i  (raw_bits_i),
    .idx_i  (hlp_sec_idx_i),
    .inv_i  (hlp_sec_inv_i),
    .bit_o  (sec_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rgn_q   <= RGN_LOW;
      prim_q  <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= req_i;
      if (req_i) begin
        rgn_q  <= rgn_d;
        prim_q <= prim_bit_i;
      end
    end
  end

  coop_puf_resolve i_resolve (
    .rgn_i  (rgn_q),
    .prim_i (prim_q),
    .sec_i  (sec_q),
    .bit_o  (bit_o)
  );

  assign valid_o  = valid_q;
  assign region_o = rgn_q;
endmodule

// File: rtl/coop_puf_regen_chk.sv
module coop_puf_regen_chk #(
  parameter int TEMP_W  = 8,
  parameter int N_PAIRS = 64,
  parameter int IDX_W   = 6
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               req_i,
  input logic [TEMP_W-1:0]  temp_i,
  input logic               prim_bit_i,
  input logic [N_PAIRS-1:0] raw_bits_i,
  input logic               hlp_valid_i,
  input logic [IDX_W-1:0]   hlp_sec_idx_i,
  input logic               hlp_sec_inv_i,
  input logic [TEMP_W-1:0]  hlp_t_lo_i,
  input logic [TEMP_W-1:0]  hlp_t_hi_i,
  input logic               bit_o,
  input logic               valid_o,
  input logic [1:0]         region_o
);
  assert_strobe_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> valid_o);
  assert_no_strobe_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !valid_o);
  assert_low_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && hlp_valid_i && temp_i < hlp_t_lo_i)
    |=> (bit_o == $past(prim_bit_i)) && (region_o == 2'd0));
  assert_band_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && hlp_valid_i && temp_i >= hlp_t_lo_i && temp_i <= hlp_t_hi_i)
    |=> (bit_o == ($past(raw_bits_i[hlp_sec_idx_i]) ^ $past(hlp_sec_inv_i)))
        && (region_o == 2'd1));
  assert_high_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && hlp_valid_i && temp_i >= hlp_t_lo_i && temp_i > hlp_t_hi_i)
    |=> (bit_o == !$past(prim_bit_i)) && (region_o == 2'd2));
  assert_bypass_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !hlp_valid_i)
    |=> (bit_o == $past(prim_bit_i)) && (region_o == 2'd3));
  assert_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> $stable(bit_o) && $stable(region_o));
endmodule

bind coop_puf_regen coop_puf_regen_chk #(
  .TEMP_W(TEMP_W), .N_PAIRS(N_PAIRS), .IDX_W(IDX_W)
) i_chk (.*);

// File: tb/test_coop_puf_regen.sv
module test_coop_puf_regen;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0;
  logic [7:0]  temp_i = '0;
  logic        prim_bit_i = 1'b0;
  logic [63:0] raw_bits_i = '0;
  logic        hlp_valid_i = 1'b0;
  logic [5:0]  hlp_sec_idx_i = '0;
  logic        hlp_sec_inv_i = 1'b0;
  logic [7:0]  hlp_t_lo_i = '0;
  logic [7:0]  hlp_t_hi_i = '0;
  logic        bit_o, valid_o;
  logic [1:0]  region_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  bit cmp_en = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  coop_puf_regen i_coop_puf_regen (.*);

  // behavioural reference
  bit m_valid = 0, m_bit = 0;
  int m_rgn = 0;
  string m_tag = "R9";

  always @(posedge clk_i) begin
    if (rst_ni) begin
      m_valid = req_i;
      if (req_i) begin
        if (!hlp_valid_i) begin
          m_rgn = 3; m_bit = prim_bit_i; m_tag = "R6";
        end else if (int'(temp_i) < int'(hlp_t_lo_i)) begin
          m_rgn = 0; m_bit = prim_bit_i;
          m_tag = (hlp_t_lo_i > hlp_t_hi_i && temp_i > hlp_t_hi_i) ? "R10" : "R2";
        end else if (int'(temp_i) > int'(hlp_t_hi_i)) begin
          m_rgn = 2; m_bit = !prim_bit_i; m_tag = "R5";
        end else begin
          m_rgn = 1;
          m_bit = raw_bits_i[hlp_sec_idx_i] ^ hlp_sec_inv_i;
          m_tag = hlp_sec_inv_i ? "R4" : "R3";
        end
      end else begin
        m_tag = "R8";
      end
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk_i) begin
    if (cmp_en && rst_ni && !done) begin
      check(valid_o == m_valid, "R7", valid_o, m_valid);
      check(bit_o == m_bit, m_tag, bit_o, m_bit);
      check(int'(region_o) == m_rgn, (m_tag == "R8") ? "R8" : "R1", region_o, m_rgn);
    end
  end

  task automatic drive(input bit rq, input int t, input bit p, input bit hv,
                       input int lo, input int hi, input int idx, input bit inv,
                       input logic [63:0] raw);
    req_i = rq; temp_i = 8'(t); prim_bit_i = p; hlp_valid_i = hv;
    hlp_t_lo_i = 8'(lo); hlp_t_hi_i = 8'(hi); hlp_sec_idx_i = 6'(idx);
    hlp_sec_inv_i = inv; raw_bits_i = raw;
    @(negedge clk_i);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      req_i = 1'b0; prim_bit_i = ~prim_bit_i; temp_i = temp_i + 8'd37;
      raw_bits_i = ~raw_bits_i;
      @(negedge clk_i);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    req_i = 1'b1;
    @(negedge clk_i);
    // R9 reset state while reset held
    check(valid_o == 1'b0, "R9", valid_o, 0);
    check(bit_o == 1'b0, "R9", bit_o, 0);
    check(region_o == 2'd0, "R9", region_o, 0);
    req_i = 1'b0;
    rst_ni = 1'b1;
    cmp_en = 1'b1;
    @(negedge clk_i);
    // R1/R2/R5 bound edges, band 100..150
    drive(1, 99, 1, 1, 100, 150, 5, 0, 64'h0);
    drive(1, 99, 0, 1, 100, 150, 5, 0, 64'h0);
    drive(1, 100, 1, 1, 100, 150, 5, 0, 64'h20);
    drive(1, 150, 1, 1, 100, 150, 5, 0, 64'h0);
    drive(1, 151, 1, 1, 100, 150, 5, 0, 64'h0);
    drive(1, 151, 0, 1, 100, 150, 5, 0, 64'h0);
    drive(1, 0, 1, 1, 100, 150, 5, 0, 64'h0);
    drive(1, 255, 1, 1, 100, 150, 5, 0, 64'h0);
    // R3/R4 extreme indices
    drive(1, 120, 0, 1, 100, 150, 0, 0, 64'h1);
    drive(1, 120, 0, 1, 100, 150, 0, 1, 64'h1);
    drive(1, 120, 1, 1, 100, 150, 63, 0, 64'h8000_0000_0000_0000);
    drive(1, 120, 1, 1, 100, 150, 63, 1, 64'h8000_0000_0000_0000);
    drive(1, 120, 1, 1, 100, 150, 62, 0, 64'h8000_0000_0000_0000);
    // R6 bypass in each region
    drive(1, 50, 1, 0, 100, 150, 3, 1, 64'hF);
    drive(1, 120, 0, 0, 100, 150, 3, 1, 64'hF);
    drive(1, 200, 1, 0, 100, 150, 3, 1, 64'hF);
    // R8 hold with changing inputs
    idle(4);
    // R10 reversed bounds lo=150 hi=100
    drive(1, 120, 1, 1, 150, 100, 7, 0, 64'h0);
    drive(1, 90, 1, 1, 150, 100, 7, 0, 64'h0);
    drive(1, 200, 1, 1, 150, 100, 7, 0, 64'h0);
    // R7 back-to-back then idle
    drive(1, 120, 1, 1, 120, 120, 9, 0, 64'h200);
    drive(0, 120, 0, 1, 120, 120, 9, 0, 64'h0);
    // random mix
    for (int i = 0; i < 400; i++) begin
      int lo = $urandom_range(0, 255);
      int hi = $urandom_range(0, 255);
      drive($urandom_range(0, 3) != 0, $urandom_range(0, 255), 1'($urandom),
            $urandom_range(0, 7) != 0, lo, hi, $urandom_range(0, 63), 1'($urandom),
            {$urandom, $urandom});
    end
    idle(2);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule